// File: doc/BRIEF.md
# I2C Bus Event Monitor

This block listens to the two wires of an I2C bus without ever driving them. A fast system clock samples the clock and data lines. The block turns what it sees into a stream of event records, one for each protocol element: start, repeated start, address byte (read or write), data byte (read or write), acknowledge or not-acknowledge, and stop. Each record carries a kind code and a byte payload where one applies. It also carries the first and last sample index of the element, read from a free-running sample counter.

The block can sit beside any bus segment as a protocol analyser front end. The event stream is a single-cycle valid pulse with the record fields beside it. A trace buffer or a filter downstream can take the records directly. There is no back-pressure: every record is presented exactly once.

Top module: `i2cmon_top`

## Requirements
- R1: While reset is held and after it is released with a quiet bus, `ev_valid` stays low. The sample counter restarts from zero when reset is released and then advances by one every clock. The index of a line change is the counter value in the cycle the synchronized line shows it, which is two clocks after the input pin changes (default synchronizer depth).
- R2: A falling data line while the clock line is high, with the monitor idle, gives one event of kind 1 (start). Its first and last index are both the index of the data-line fall.
- R3: A rising data line while the clock line is high gives an event of kind 9 (stop), with first and last index equal. A stop returns the monitor to idle and forgets the transfer direction. Clock-line rising edges seen while idle produce no events.
- R4: A start condition seen while a transfer is active gives kind 2 (repeated start). Indices follow the rule of R2, and the next byte is again taken as an address.
- R5: Bits are taken on every clock-line rising edge, most significant first. The first byte after any start is an address byte: kind 3 when its bit 0 is 0 (write) and kind 4 when it is 1 (read). The payload is the byte with bit 0 forced to 0.
- R6: Every later byte is a data byte: kind 5 if the latched direction is write and kind 6 if it is read. The payload is the whole byte.
- R7: The ninth bit of each byte gives kind 7 (acknowledge) when low and kind 8 (not-acknowledge) when high, with payload 0. First and last index are both the index of the ninth rising edge. This record is presented on the clock cycle right after the byte record.
- R8: A byte record's first index is the index of its first rising clock edge. Its last index is one less than the index of its ninth rising edge.
- R9: A start or stop that arrives before a byte is complete discards the partial bits, and no byte or acknowledge record is produced for them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| ev_valid | output | 1 | One-cycle strobe for a new record |
| ev_kind | output | 4 | Record kind code (1 to 9, see requirements) |
| ev_data | output | 8 | Byte payload, 0 for non-byte records |
| ev_first | output | TS_W (32) | First sample index of the element |
| ev_last | output | TS_W (32) | Last sample index of the element |

## Verification
The hardest case to reach from the pins is a start or stop that lands partway through a byte. On a real bus the setup for a repeated start or a stop itself makes an extra clock rising edge, so the bench drives those setup edges as a master would. It also cuts a byte after three and after five bits, and then checks that only the condition records appear. The bench also clocks the bus while idle, between a stop and the next start, to show those bits vanish. Every index is predicted from a bench-side edge count plus the two synchronizer stages.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
   typedef enum logic [3:0] {
      EV_NONE    = 4'd0,
      EV_START   = 4'd1,
      EV_RSTART  = 4'd2,
      EV_ADDR_WR = 4'd3,
      EV_ADDR_RD = 4'd4,
      EV_DATA_WR = 4'd5,
      EV_DATA_RD = 4'd6,
      EV_ACK     = 4'd7,
      EV_NACK    = 4'd8,
      EV_STOP    = 4'd9
   } ev_kind_e;

   localparam int BYTE_W  = 8;
   localparam int BITS_PB = BYTE_W + 1;
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
   parameter int         WIDTH     = 2,
   parameter int         STAGES    = 2,
   parameter logic       RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("i2cmon_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) stg[0] <= {WIDTH{RESET_VAL}};
      else     stg[0] <= d;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stg[g] <= {WIDTH{RESET_VAL}};
         else     stg[g] <= stg[g-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond (
   input  logic clk,
   input  logic rst,
   input  logic scl,
   input  logic sda,
   output logic start_det,
   output logic stop_det,
   output logic bit_stb,
   output logic bit_val
);
   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   always_comb begin
      start_det = 1'b0;
      stop_det  = 1'b0;
      bit_stb   = 1'b0;
      bit_val   = sda;
      if (sda_q && !sda && scl)        start_det = 1'b1;
      else if (!scl)                   start_det = 1'b0;
      else if (!scl_q)                 bit_stb   = 1'b1;
      else if (!sda_q && sda)          stop_det  = 1'b1;
   end

   // R2
   cond_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $countones({start_det, stop_det, bit_stb}) <= 1);
endmodule

// File: rtl/i2cmon_core.sv
module i2cmon_core
   import i2cmon_pkg::*;
#(
   parameter int TS_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic [TS_W-1:0]   ts,
   output logic              ev_valid,
   output ev_kind_e          ev_kind,
   output logic [BYTE_W-1:0] ev_data,
   output logic [TS_W-1:0]   ev_first,
   output logic [TS_W-1:0]   ev_last
);
   localparam int CNT_W = $clog2(BITS_PB + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   logic              active, addr_ph, dir_rd;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [TS_W-1:0]   first_ts, ack_ts;
   logic              ack_pend, ack_high;

   always_ff @(posedge clk) begin
      if (rst) begin
         active   <= 1'b0;
         addr_ph  <= 1'b0;
         dir_rd   <= 1'b0;
         bitcnt   <= '0;
         shreg    <= '0;
         first_ts <= '0;
         ack_ts   <= '0;
         ack_pend <= 1'b0;
         ack_high <= 1'b0;
         ev_valid <= 1'b0;
         ev_kind  <= EV_NONE;
         ev_data  <= '0;
         ev_first <= '0;
         ev_last  <= '0;
      end else begin
         ev_valid <= 1'b0;
         if (ack_pend) begin
            ev_valid <= 1'b1;
            ev_kind  <= ack_high ? EV_NACK : EV_ACK;
            ev_data  <= '0;
            ev_first <= ack_ts;
            ev_last  <= ack_ts;
            ack_pend <= 1'b0;
         end
         if (start_det) begin
            ev_valid <= 1'b1;
            ev_kind  <= active ? EV_RSTART : EV_START;
            ev_data  <= '0;
            ev_first <= ts;
            ev_last  <= ts;
            active   <= 1'b1;
            addr_ph  <= 1'b1;
            bitcnt   <= '0;
            shreg    <= '0;
         end else if (stop_det) begin
            ev_valid <= 1'b1;
            ev_kind  <= EV_STOP;
            ev_data  <= '0;
            ev_first <= ts;
            ev_last  <= ts;
            active   <= 1'b0;
            addr_ph  <= 1'b0;
            dir_rd   <= 1'b0;
            bitcnt   <= '0;
         end else if (bit_stb && active) begin
            if (bitcnt == LAST_BIT) begin
               ev_valid <= 1'b1;
               ev_first <= first_ts;
               ev_last  <= ts - TS_W'(1);
               if (addr_ph) begin
                  ev_kind <= shreg[0] ? EV_ADDR_RD : EV_ADDR_WR;
                  ev_data <= {shreg[BYTE_W-1:1], 1'b0};
                  dir_rd  <= shreg[0];
               end else begin
                  ev_kind <= dir_rd ? EV_DATA_RD : EV_DATA_WR;
                  ev_data <= shreg;
               end
               ack_pend <= 1'b1;
               ack_high <= bit_val;
               ack_ts   <= ts;
               bitcnt   <= '0;
               addr_ph  <= 1'b0;
            end else begin
               if (bitcnt == '0) first_ts <= ts;
               shreg  <= {shreg[BYTE_W-2:0], bit_val};
               bitcnt <= bitcnt + CNT_W'(1);
            end
         end
      end
   end

   logic byte_ev, ack_ev;
   assign byte_ev = ev_valid && (ev_kind inside {EV_ADDR_WR, EV_ADDR_RD, EV_DATA_WR, EV_DATA_RD});
   assign ack_ev  = ev_valid && (ev_kind inside {EV_ACK, EV_NACK});

   // R7
   byte_then_ack_chk: assert property (@(posedge clk) disable iff (rst)
      byte_ev |=> ack_ev);
   // R7
   ack_point_chk: assert property (@(posedge clk) disable iff (rst)
      ack_ev |-> (ev_first == ev_last));
   // R8
   byte_span_chk: assert property (@(posedge clk) disable iff (rst)
      byte_ev |=> (ev_first == $past(ev_last) + TS_W'(1)));
   // R3
   stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
      stop_det |=> !active);
   // R9
   bitcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      bitcnt <= LAST_BIT);
endmodule

// File: rtl/i2cmon_top.sv
module i2cmon_top
   import i2cmon_pkg::*;
#(
   parameter int TS_W        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            scl_in,
   input  logic            sda_in,
   output logic            ev_valid,
   output logic [3:0]      ev_kind,
   output logic [7:0]      ev_data,
   output logic [TS_W-1:0] ev_first,
   output logic [TS_W-1:0] ev_last
);
   if (TS_W < 8) begin : g_bad_ts
      $error("i2cmon_top: TS_W must be at least 8");
   end

   logic [TS_W-1:0] sample_cnt;
   logic [1:0]      lines_s;
   logic            start_det, stop_det, bit_stb, bit_val;
   ev_kind_e        kind_w;

   always_ff @(posedge clk) begin
      if (rst) sample_cnt <= '0;
      else     sample_cnt <= sample_cnt + TS_W'(1);
   end

   i2cmon_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
      .clk (clk),
      .rst (rst),
      .d   ({scl_in, sda_in}),
      .q   (lines_s)
   );

   i2cmon_cond cond_i (
      .clk       (clk),
      .rst       (rst),
      .scl       (lines_s[1]),
      .sda       (lines_s[0]),
      .start_det (start_det),
      .stop_det  (stop_det),
      .bit_stb   (bit_stb),
      .bit_val   (bit_val)
   );

   i2cmon_core #(.TS_W(TS_W)) core_i (
      .clk       (clk),
      .rst       (rst),
      .start_det (start_det),
      .stop_det  (stop_det),
      .bit_stb   (bit_stb),
      .bit_val   (bit_val),
      .ts        (sample_cnt),
      .ev_valid  (ev_valid),
      .ev_kind   (kind_w),
      .ev_data   (ev_data),
      .ev_first  (ev_first),
      .ev_last   (ev_last)
   );

   assign ev_kind = kind_w;
endmodule

// File: tb/i2cmon_top_tb_top.sv
`timescale 1ns/1ps
module i2cmon_top_tb_top;
   localparam int GAP = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        scl_in = 1'b1;
   logic        sda_in = 1'b1;
   logic        ev_valid;
   logic [3:0]  ev_kind;
   logic [7:0]  ev_data;
   logic [31:0] ev_first, ev_last;

   int n_chk = 0;
   int n_bad = 0;
   int bcnt  = 0;

   logic [3:0]  obs_k [64], exp_k [64];
   logic [7:0]  obs_d [64], exp_d [64];
   logic [31:0] obs_f [64], exp_f [64], obs_l [64], exp_l [64];
   int obs_n = 0;
   int exp_n = 0;

   always #2 clk = ~clk;

   i2cmon_top dut_i (
      .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
      .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_data(ev_data),
      .ev_first(ev_first), .ev_last(ev_last)
   );

   always @(posedge clk) if (!rst) bcnt <= bcnt + 1;

   always @(negedge clk) begin
      if (!rst && ev_valid && obs_n < 64) begin
         obs_k[obs_n] = ev_kind;
         obs_d[obs_n] = ev_data;
         obs_f[obs_n] = ev_first;
         obs_l[obs_n] = ev_last;
         obs_n = obs_n + 1;
      end
   end

   function automatic string tag_of(input logic [3:0] k);
      case (k)
         4'd1: return "R2";
         4'd2: return "R4";
         4'd3, 4'd4: return "R5/R8";
         4'd5, 4'd6: return "R6/R8";
         4'd7, 4'd8: return "R7";
         4'd9: return "R3";
         default: return "R1";
      endcase
   endfunction

   task automatic check(input bit ok, input string msg);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s", msg);
      end
   endtask

   task automatic push(input logic [3:0] k, input logic [7:0] d, input int f, input int l);
      exp_k[exp_n] = k; exp_d[exp_n] = d; exp_f[exp_n] = f; exp_l[exp_n] = l;
      exp_n++;
   endtask

   task automatic clear_lists();
      @(negedge clk);
      obs_n = 0;
      exp_n = 0;
   endtask

   task automatic compare(input string cnt_tag);
      repeat (8) @(negedge clk);
      check(obs_n == exp_n, $sformatf("%s record count actual %0d expected %0d", cnt_tag, obs_n, exp_n));
      for (int i = 0; i < exp_n && i < obs_n; i++) begin
         check(obs_k[i] == exp_k[i] && obs_d[i] == exp_d[i] && obs_f[i] == exp_f[i] && obs_l[i] == exp_l[i],
               $sformatf("%s record %0d actual k%0d d%02h [%0d,%0d] expected k%0d d%02h [%0d,%0d]",
                         tag_of(exp_k[i]), i, obs_k[i], obs_d[i], obs_f[i], obs_l[i],
                         exp_k[i], exp_d[i], exp_f[i], exp_l[i]));
      end
   endtask

   task automatic put_scl(input logic v, output int ts);
      @(negedge clk);
      scl_in = v;
      ts = bcnt + 2;
      repeat (GAP) @(negedge clk);
   endtask

   task automatic put_sda(input logic v, output int ts);
      @(negedge clk);
      sda_in = v;
      ts = bcnt + 2;
      repeat (GAP) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, output int ts);
      int t;
      put_sda(b, t);
      put_scl(1'b1, ts);
      put_scl(1'b0, t);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic ackb, output int f, output int a);
      int t;
      for (int i = 7; i >= 0; i--) begin
         send_bit(b[i], t);
         if (i == 7) f = t;
      end
      send_bit(ackb, a);
   endtask

   task automatic do_start(input bit repeated);
      int t;
      if (repeated) begin
         put_sda(1'b1, t);
         put_scl(1'b1, t);
      end
      put_sda(1'b0, t);
      push(repeated ? 4'd2 : 4'd1, 8'h00, t, t);
      put_scl(1'b0, t);
   endtask

   task automatic do_stop();
      int t;
      put_sda(1'b0, t);
      put_scl(1'b1, t);
      put_sda(1'b1, t);
      push(4'd9, 8'h00, t, t);
   endtask

   task automatic byte_ev(input logic [3:0] k, input logic [7:0] b, input logic [7:0] pay, input logic ackb);
      int f, a;
      send_byte(b, ackb, f, a);
      push(k, pay, f, a - 1);
      push(ackb ? 4'd8 : 4'd7, 8'h00, a, a);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(ev_valid == 1'b0, $sformatf("R1 valid in reset actual %0b expected 0", ev_valid));
      rst = 1'b0;
      clear_lists();
      compare("R1");
   endtask

   task automatic t_write();
      clear_lists();
      do_start(1'b0);
      byte_ev(4'd3, 8'hA0, 8'hA0, 1'b0);
      byte_ev(4'd5, 8'h3C, 8'h3C, 1'b0);
      byte_ev(4'd5, 8'hFF, 8'hFF, 1'b1);
      do_stop();
      compare("R5/R6");
   endtask

   task automatic t_read_rs();
      clear_lists();
      do_start(1'b0);
      byte_ev(4'd3, 8'h92, 8'h92, 1'b0);
      do_start(1'b1);
      byte_ev(4'd4, 8'h93, 8'h92, 1'b0);
      byte_ev(4'd6, 8'h5A, 8'h5A, 1'b0);
      byte_ev(4'd6, 8'h81, 8'h81, 1'b1);
      do_stop();
      compare("R4/R6");
   endtask

   task automatic t_partial_idle();
      int t;
      clear_lists();
      do_start(1'b0);
      for (int i = 0; i < 3; i++) send_bit(i[0], t);
      do_stop();
      put_scl(1'b0, t);
      for (int i = 0; i < 4; i++) send_bit(~i[0], t);
      put_sda(1'b1, t);
      put_scl(1'b1, t);
      do_start(1'b0);
      for (int i = 0; i < 5; i++) send_bit(1'b1, t);
      do_start(1'b1);
      byte_ev(4'd4, 8'h01, 8'h00, 1'b1);
      do_stop();
      compare("R9/R3");
   endtask

   initial begin
      t_reset();
      t_write();
      t_read_rs();
      t_partial_idle();
      t_write();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired R1 actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule